// File: doc/BRIEF.md
# Transmit DMA Byte Packer with End-of-Packet Tagging

This block sits between the byte fetch engine of an Ethernet transmit DMA channel and the channel's output FIFO. Software describes a packet as one or more descriptors. Each descriptor has a byte count, and the final descriptor of the packet carries a last flag. The block takes one descriptor at a time through a load port. It then accepts that many bytes over a valid/ready byte stream and counts the remaining bytes down. The bytes are packed little-endian into 32-bit FIFO words.

A full word goes to the FIFO in the same cycle that its fourth byte is accepted. When a descriptor's count is used up, a one-cycle finished pulse is raised. If that descriptor carries the last flag, the word holding the packet's final byte is written at once. That word is tagged end-of-packet, with a field giving how many of its bytes are valid. When a descriptor that is not the last one ends part-way through a word, the partial word is kept. The next descriptor's bytes fill the remaining lanes.

Back-pressure rules: a byte moves only in a cycle where `byte_valid` and `byte_ready` are both high. `byte_ready` is high only while the current descriptor has bytes left and `fifo_full` is low. The producer must hold a byte steady until it is taken. The FIFO write port has no ready signal of its own: `fifo_wr` is never raised while `fifo_full` is high. A descriptor is taken when `desc_valid` and `desc_ready` are both high.

Top module: `tx_byte_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, with no inputs asserted: `desc_ready` is 1, and `byte_ready`, `fifo_wr` and `desc_done` are 0.
- R2: A descriptor is loaded when `desc_valid` and `desc_ready` are both high. While a loaded descriptor has bytes remaining, `desc_ready` is 0 and `byte_ready` equals the inverse of `fifo_full`. Once the count reaches zero, `desc_ready` returns to 1.
- R3: The k-th byte of a word, counted from 0, lands in bits [8k+7:8k] of `fifo_data`. A word is written (`fifo_wr` = 1) in the same cycle its fourth byte is accepted. On that write `fifo_nbytes` is 0, which means four bytes are valid.
- R4: `desc_done` is high for exactly the cycle in which a descriptor's final byte is accepted. It is low in all other cycles that carry a byte or a stall.
- R5: When the final byte of a descriptor loaded with the last flag set is accepted, the word holding it is written in that cycle with `fifo_eop` = 1. On that write `fifo_nbytes` is the number of valid bytes modulo 4, so 0 means four bytes are valid. The unused upper lanes are zero.
- R6: When a descriptor without the last flag ends before a word is full, nothing is written. The next descriptor's first byte goes into the next free lane of the same word.
- R7: Every FIFO write without `fifo_eop` carries four valid bytes (`fifo_nbytes` = 0). A partial word is written only together with end-of-packet.
- R8: While `fifo_full` is high, `byte_ready` and `fifo_wr` are 0. A byte held across a stall is accepted exactly once, after the stall ends.
- R9: Loading a descriptor with a count of 0 raises `desc_done` in the load cycle. In that cycle nothing is written and `desc_ready` stays 1. The descriptor's last flag has no effect, so any partial word is kept for the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered on the load port |
| desc_ready | output | 1 | Load port can take a descriptor (no bytes outstanding) |
| desc_count | input | CNT_W | Byte count of the offered descriptor |
| desc_last | input | 1 | Offered descriptor is the last one of its packet |
| byte_valid | input | 1 | A byte is offered on `byte_data` |
| byte_ready | output | 1 | The block accepts the offered byte this cycle |
| byte_data | input | 8 | Byte value |
| fifo_full | input | 1 | Output FIFO cannot take a word |
| fifo_wr | output | 1 | Write strobe for the output FIFO |
| fifo_data | output | 32 | Packed word, byte 0 in bits [7:0] |
| fifo_eop | output | 1 | Written word ends the packet |
| fifo_nbytes | output | 2 | Valid bytes in the written word modulo 4 (0 = four) |
| desc_done | output | 1 | Finished pulse for the current descriptor |

## Verification
Three things can coincide in one cycle: the finished pulse, a word write with its end-of-packet tag, and the word filling its fourth lane. The bench provokes this by sweeping both descriptor counts of a two-descriptor packet from 0 to 5. Every alignment of a descriptor end against the lane position then occurs, including a last descriptor ending exactly on lane 3 and a zero-count descriptor arriving while a word is half full. Stalls from `fifo_full` are added on some bytes, so the final byte is sometimes held over. In each accepting cycle, the bench compares the write strobe, data, tag, valid count and finished pulse against values it derives arithmetically from the lane position and the remaining count.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // number of valid bytes encoded modulo the lane count
  function automatic logic [1:0] fill_code(input logic [1:0] lane);
    return lane + 2'd1;
  endfunction
endpackage

// File: rtl/txp_desc_tracker.sv
module txp_desc_tracker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_count,
  input  logic             load_last,
  input  logic             take,
  output logic             load_ready,
  output logic             busy,
  output logic             final_byte,
  output logic             last_q,
  output logic             done
);
  logic [CNT_W-1:0] remain_q;
  logic             load_fire;

  assign busy       = (remain_q != '0);
  assign load_ready = ~busy;
  assign load_fire  = load_valid & load_ready;
  assign final_byte = (remain_q == CNT_W'(1));
  assign done       = (load_fire & (load_count == '0)) | (take & final_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      last_q   <= 1'b0;
    end else if (load_fire) begin
      remain_q <= load_count;
      last_q   <= load_last;
    end else if (take) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/txp_lane_packer.sv
module txp_lane_packer
  import txp_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  byte_t                   byte_in,
  input  logic                    flush,
  output logic [LANES*BYTE_W-1:0] word,
  output logic [LANE_W-1:0]       lane,
  output logic                    top_lane,
  output logic                    emit
);
  byte_t             acc_q  [LANES];
  byte_t             merged [LANES];
  logic [LANE_W-1:0] lane_q;

  assign lane     = lane_q;
  assign top_lane = (lane_q == LANE_W'(LANES - 1));
  assign emit     = take & (top_lane | flush);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i] = (take && lane_q == LANE_W'(i)) ? byte_in : acc_q[i];
    assign word[i*BYTE_W +: BYTE_W] = merged[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      for (int i = 0; i < LANES; i++) acc_q[i] <= '0;
    end else if (take) begin
      if (emit) begin
        lane_q <= '0;
        for (int i = 0; i < LANES; i++) acc_q[i] <= '0;
      end else begin
        lane_q <= lane_q + LANE_W'(1);
        acc_q[lane_q] <= byte_in;
      end
    end
  end
endmodule

// File: rtl/tx_byte_packer.sv
module tx_byte_packer
  import txp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [CNT_W-1:0] desc_count,
  input  logic             desc_last,
  input  logic             byte_valid,
  output logic             byte_ready,
  input  logic [7:0]       byte_data,
  input  logic             fifo_full,
  output logic             fifo_wr,
  output logic [31:0]      fifo_data,
  output logic             fifo_eop,
  output logic [1:0]       fifo_nbytes,
  output logic             desc_done
);
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic              busy;
  logic              final_byte;
  logic              last_q;
  logic              take;
  logic              flush;
  logic              top_lane;
  logic [LANE_W-1:0] lane;

  assign byte_ready = busy & ~fifo_full;
  assign take       = byte_valid & byte_ready;
  assign flush      = final_byte & last_q;

  txp_desc_tracker #(.CNT_W(CNT_W)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (desc_valid),
    .load_count (desc_count),
    .load_last  (desc_last),
    .take       (take),
    .load_ready (desc_ready),
    .busy       (busy),
    .final_byte (final_byte),
    .last_q     (last_q),
    .done       (desc_done)
  );

  txp_lane_packer #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .byte_in  (byte_data),
    .flush    (flush),
    .word     (fifo_data),
    .lane     (lane),
    .top_lane (top_lane),
    .emit     (fifo_wr)
  );

  assign fifo_eop    = take & flush;
  assign fifo_nbytes = fill_code(lane);
endmodule

// File: rtl/txp_checker.sv
module txp_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic [CNT_W-1:0] desc_count,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic             fifo_full,
  input logic             fifo_wr,
  input logic             fifo_eop,
  input logic [1:0]       fifo_nbytes,
  input logic             desc_done
);
  AST_FULL_BLOCKS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !byte_ready); // R8
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) fifo_full |-> !fifo_wr); // R8
  AST_EOP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) fifo_eop |-> (fifo_wr && desc_done)); // R5
  AST_PARTIAL_ONLY_EOP: assert property (@(posedge clk) disable iff (!rst_n) (fifo_wr && fifo_nbytes != 2'd0) |-> fifo_eop); // R7
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) byte_ready |-> !desc_ready); // R2
  AST_WRITE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> (byte_valid && byte_ready)); // R3
  AST_ZERO_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n) (desc_valid && desc_ready && desc_count == '0) |-> (desc_done && !fifo_wr)); // R9
  AST_ZERO_LOAD_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n) (desc_valid && desc_ready && desc_count == '0) |=> desc_ready); // R9
endmodule

bind tx_byte_packer txp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .desc_valid  (desc_valid),
  .desc_ready  (desc_ready),
  .desc_count  (desc_count),
  .byte_valid  (byte_valid),
  .byte_ready  (byte_ready),
  .fifo_full   (fifo_full),
  .fifo_wr     (fifo_wr),
  .fifo_eop    (fifo_eop),
  .fifo_nbytes (fifo_nbytes),
  .desc_done   (desc_done)
);

// File: tb/tx_byte_packer_tb.sv
module tx_byte_packer_tb;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             desc_valid = 1'b0;
  logic             desc_ready;
  logic [CNT_W-1:0] desc_count = '0;
  logic             desc_last = 1'b0;
  logic             byte_valid = 1'b0;
  logic             byte_ready;
  logic [7:0]       byte_data = '0;
  logic             fifo_full = 1'b0;
  logic             fifo_wr;
  logic [31:0]      fifo_data;
  logic             fifo_eop;
  logic [1:0]       fifo_nbytes;
  logic             desc_done;

  int total = 0;
  int bad = 0;
  int mlane = 0;
  logic [31:0] macc = '0;
  logic [7:0] bval = 8'h01;

  always #10 clk = ~clk;

  tx_byte_packer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_count(desc_count), .desc_last(desc_last),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_eop(fifo_eop), .fifo_nbytes(fifo_nbytes), .desc_done(desc_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one byte, held through 'stalls' full cycles, then accepted
  task automatic send_byte(input bit fin, input bit last, input int stalls);
    logic [31:0] exp_word;
    bit exp_wr;
    bit exp_eop;
    string tag;
    byte_valid = 1'b1;
    byte_data  = bval;
    for (int s = 0; s < stalls; s++) begin
      fifo_full = 1'b1;
      #2;
      chk("R8", "ready while full", byte_ready, 0);
      chk("R8", "write while full", fifo_wr, 0);
      chk("R4", "done while stalled", desc_done, 0);
      step();
    end
    fifo_full = 1'b0;
    #2;
    chk("R2", "byte_ready", byte_ready, 1);
    exp_word = macc | (32'(bval) << (8 * mlane));
    exp_eop  = fin && last;
    exp_wr   = (mlane == 3) || exp_eop;
    tag = exp_eop ? "R5" : ((fin && mlane != 3) ? "R6" : "R3");
    chk(tag, "fifo_wr", fifo_wr, exp_wr);
    chk("R5", "fifo_eop", fifo_eop, exp_eop);
    if (exp_wr) begin
      chk(tag, "fifo_data", fifo_data, exp_word);
      chk(exp_eop ? "R5" : "R7", "fifo_nbytes", fifo_nbytes, (mlane + 1) % 4);
    end
    chk("R4", "desc_done", desc_done, fin);
    step();
    if (exp_wr) begin
      macc = '0;
      mlane = 0;
    end else begin
      macc = exp_word;
      mlane = mlane + 1;
    end
    bval = bval + 8'd1;
    byte_valid = 1'b0;
  endtask

  task automatic run_desc(input int cnt, input bit last, input int pat);
    chk("R2", "desc_ready before load", desc_ready, 1);
    desc_valid = 1'b1;
    desc_count = CNT_W'(cnt);
    desc_last  = last;
    #2;
    chk("R9", "done on load", desc_done, (cnt == 0));
    chk("R9", "write on load", fifo_wr, 0);
    step();
    desc_valid = 1'b0;
    #2;
    chk("R2", "desc_ready after load", desc_ready, (cnt == 0));
    for (int k = 0; k < cnt; k++)
      send_byte(k == cnt - 1, last, ((k + cnt) % 3 == 0) ? pat : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "desc_ready in reset", desc_ready, 1);
    chk("R1", "byte_ready in reset", byte_ready, 0);
    chk("R1", "fifo_wr in reset", fifo_wr, 0);
    chk("R1", "desc_done in reset", desc_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1", "desc_ready after reset", desc_ready, 1);
    chk("R1", "byte_ready after reset", byte_ready, 0);

    for (int pat = 0; pat < 3; pat++) begin
      for (int c1 = 0; c1 < 6; c1++) begin
        for (int c2 = 0; c2 < 6; c2++) begin
          run_desc(c1, 1'b0, pat);
          run_desc(c2, 1'b1, pat);
          #2;
          chk("R4", "idle done", desc_done, 0);
          chk("R3", "idle write", fifo_wr, 0);
          step();
        end
      end
    end
    // three descriptors in one packet, then a long one
    run_desc(1, 1'b0, 1);
    run_desc(2, 1'b0, 1);
    run_desc(7, 1'b1, 2);
    run_desc(9, 1'b1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule